// File: doc/BRIEF.md
# Privilege Level Exception Controller

This block keeps a processor's current privilege level (0 lowest, 3 highest), its stack-select bit, its four exception mask bits and the security state of the two lowest levels. It carries out the hardware part of taking an exception and of returning from one. On entry it banks the interrupted program counter and status word into the registers of the target level, switches to that level's stack pointer, raises all masks and issues a redirect to a vector address. On return it takes the program counter and the status back from the current level's bank and drops to the level encoded in that status.

Exception requests arrive on a valid/ready channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` falls in two cases: an IRQ or FIQ request whose mask bit is set at the current level, and a cycle in which a return is strobed. A masked request stays pending for as long as the requester holds `req_valid`. Because interrupts are level-like, the requester may drop `req_valid` before acceptance without any effect. The return strobe, the configuration write and the banked-register write are plain single-cycle controls. All results appear one cycle after the accepting edge.

The status word uses these fields: bit 0 is stack select (1 = the level's own pointer), bits [3:2] are the level, and bits [9:6] are the D, A, I and F masks. The configuration word uses these bits: bit 0 makes levels 0 and 1 non-secure, bit 1 routes IRQ to level 3, bit 2 routes FIQ to level 3, and bit 10 selects 64-bit state for level 1.

Top module: `exc_level_ctrl`

## Requirements
- R1: After reset the block is at level 3 with stack select 1, all four masks set, levels 0/1 secure, no redirect and no illegal flag.
- R2: A supervisor call or a synchronous abort (kind 0 or 4) targets level 1 from level 0 and the current level otherwise. An accepted exception never lowers the level.
- R3: A secure monitor call (kind 1) targets level 3 from any level.
- R4: IRQ (kind 2) targets level 3 when configuration bit 1 is set, and FIQ (kind 3) does the same when bit 2 is set. Otherwise each follows the rule of R2.
- R5: On entry, the target level's link register takes `req_pc`. Its saved-status register takes `req_status` with bits 0, [3:2] and [9:6] replaced by the interrupted stack select, level and masks. The new state has stack select 1 and masks 4'hF.
- R6: One cycle after an accepted entry, `redir_valid` pulses and `redir_pc` = base of target level + kind offset (0x080 IRQ, 0x100 FIQ, 0 otherwise) + 0x200 if taken from the same level or 0x400 if taken from a lower level. The bases are 0x1000, 0x2000 and 0x3000 for levels 1, 2 and 3 by default.
- R7: `req_ready` is low for IRQ while mask I (status bit 7) is set, for FIQ while mask F (bit 6) is set, and whenever `eret_i` is high. A request that is not accepted changes nothing.
- R8: A return at level n sets the level, stack select and masks from level n's saved status and redirects to level n's link register one cycle later.
- R9: The active stack bank is the current level when stack select is 1 and the level is above 0, and bank 0 otherwise. Stack writes reach only the active bank, so bank 0 keeps its value while higher levels run.
- R10: `cur_secure` is 1 at level 3, 0 at level 2, and the inverse of configuration bit 0 at levels 0 and 1. `lvl1_64bit` follows configuration bit 10.
- R11: A return at level 0, a return to a higher level, a return to level 2 while bit 0 is clear, or any target at an absent level pulses `illegal` for one cycle and leaves the state unchanged with no redirect.
- R12: Writing saved status 0x3C5 at level 3 and then returning lands at level 1 with its own stack and all masks set.
- R13: A banked write (`bank_sel` 0 link, 1 saved status, 2 stack) targets the current level. Link and status writes at level 0 have no effect, and `cur_link` and `cur_saved` read 0 there. A banked write in a cycle with an accepted request or a return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_kind | input | 3 | 0 supervisor call, 1 monitor call, 2 IRQ, 3 FIQ, 4 synchronous abort |
| req_pc | input | PC_W | Interrupted program counter |
| req_status | input | ST_W | Status word at the time of the request |
| eret_i | input | 1 | Exception return strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | CFG_W | Configuration write data |
| bank_we | input | 1 | Banked register write enable |
| bank_sel | input | 2 | 0 link, 1 saved status, 2 stack pointer |
| bank_wdata | input | PC_W | Banked register write data |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | PC_W | Redirect target (vector or return address) |
| illegal | output | 1 | One-cycle illegal transition pulse |
| cur_level | output | 2 | Current privilege level |
| cur_secure | output | 1 | Current security state |
| cur_status | output | ST_W | Current stack select, level and masks in status layout |
| sp_bank | output | 2 | Index of the active stack bank |
| sp_value | output | PC_W | Active stack pointer |
| cur_link | output | PC_W | Current level's link register |
| cur_saved | output | ST_W | Current level's saved status |
| lvl1_64bit | output | 1 | Level 1 64-bit execution state |

## Verification
The bench tests whether the level-0 stack survives a full entry and return. A design that banks all stacks in one register would hand back the kernel's pointer. It also tests whether a supervisor call at level 2 stays at level 2 and uses the same-level offset. A design that always moved to level 1 would lower the privilege, and one that always added 0x400 would land on the wrong vector. Masked interrupts are held while valid is high, and a design that accepted them would redirect with the wrong saved state. Illegal returns (at level 0, upward, and to level 2 while secure) are checked to leave the level and masks frozen, where a careless design would apply the saved status anyway.

// File: rtl/exc_lvl_pkg.sv
package exc_lvl_pkg;

  typedef enum logic [2:0] {
    EK_SVC   = 3'd0,
    EK_SMC   = 3'd1,
    EK_IRQ   = 3'd2,
    EK_FIQ   = 3'd3,
    EK_ABORT = 3'd4
  } exc_kind_e;

  typedef enum logic [1:0] {
    BK_LINK = 2'd0,
    BK_STAT = 2'd1,
    BK_SP   = 2'd2
  } bank_sel_e;

  // status word field positions
  localparam int ST_SPSEL   = 0;
  localparam int ST_LVL_LO  = 2;
  localparam int ST_MASK_LO = 6;

  // configuration word bit positions
  localparam int CFG_NS     = 0;
  localparam int CFG_IRQ3   = 1;
  localparam int CFG_FIQ3   = 2;
  localparam int CFG_L1W64  = 10;

  // vector offsets
  localparam logic [11:0] OFF_IRQ   = 12'h080;
  localparam logic [11:0] OFF_FIQ   = 12'h100;
  localparam logic [11:0] OFF_SAME  = 12'h200;
  localparam logic [11:0] OFF_LOWER = 12'h400;

  typedef struct packed {
    logic [1:0] lvl;
    logic       spsel;
    logic [3:0] daif;   // D, A, I, F from msb to lsb
  } pstate_t;

endpackage

// File: rtl/exc_lvl_route.sv
module exc_lvl_route
  import exc_lvl_pkg::*;
#(
  parameter bit HAS_L2 = 1'b1,
  parameter bit HAS_L3 = 1'b1
) (
  input  logic [2:0] kind,
  input  logic [1:0] cur_lvl,
  input  logic       irq_to_top,
  input  logic       fiq_to_top,
  output logic [1:0] tgt_lvl,
  output logic       tgt_absent
);

  logic [1:0] floor_lvl;

  assign floor_lvl = (cur_lvl == 2'd0) ? 2'd1 : cur_lvl;

  always_comb begin
    unique case (exc_kind_e'(kind))
      EK_SMC:  tgt_lvl = 2'd3;
      EK_IRQ:  tgt_lvl = irq_to_top ? 2'd3 : floor_lvl;
      EK_FIQ:  tgt_lvl = fiq_to_top ? 2'd3 : floor_lvl;
      default: tgt_lvl = floor_lvl;
    endcase
  end

  assign tgt_absent = ((tgt_lvl == 2'd3) && !HAS_L3) ||
                      ((tgt_lvl == 2'd2) && !HAS_L2);

endmodule

// File: rtl/exc_lvl_vector.sv
module exc_lvl_vector
  import exc_lvl_pkg::*;
#(
  parameter int              PC_W    = 64,
  parameter logic [PC_W-1:0] BASE_L1 = 'h1000,
  parameter logic [PC_W-1:0] BASE_L2 = 'h2000,
  parameter logic [PC_W-1:0] BASE_L3 = 'h3000
) (
  input  logic [2:0]      kind,
  input  logic [1:0]      cur_lvl,
  input  logic [1:0]      tgt_lvl,
  output logic [PC_W-1:0] vec
);

  localparam int PAD = PC_W - 12;

  logic [PC_W-1:0] base;
  logic [11:0]     kind_off;
  logic [11:0]     from_off;

  always_comb begin
    unique case (tgt_lvl)
      2'd2:    base = BASE_L2;
      2'd3:    base = BASE_L3;
      default: base = BASE_L1;
    endcase
  end

  always_comb begin
    unique case (exc_kind_e'(kind))
      EK_IRQ:  kind_off = OFF_IRQ;
      EK_FIQ:  kind_off = OFF_FIQ;
      default: kind_off = 12'h000;
    endcase
  end

  assign from_off = (tgt_lvl == cur_lvl) ? OFF_SAME : OFF_LOWER;

  assign vec = base + {{PAD{1'b0}}, kind_off} + {{PAD{1'b0}}, from_off};

endmodule

// File: rtl/exc_lvl_bank.sv
module exc_lvl_bank
  import exc_lvl_pkg::*;
#(
  parameter int PC_W   = 64,
  parameter int ST_W   = 32,
  parameter bit HAS_L2 = 1'b1,
  parameter bit HAS_L3 = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ent_en,
  input  logic [1:0]      ent_lvl,
  input  logic [PC_W-1:0] ent_pc,
  input  logic [ST_W-1:0] ent_st,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [1:0]      wr_lvl,
  input  logic [1:0]      wr_sp_idx,
  input  logic [PC_W-1:0] wr_data,
  input  logic [1:0]      rd_lvl,
  input  logic [1:0]      sp_idx,
  output logic [PC_W-1:0] rd_link,
  output logic [ST_W-1:0] rd_stat,
  output logic [PC_W-1:0] sp_q
);

  localparam int NLVL = 4;

  logic [PC_W-1:0] link_w [NLVL];
  logic [ST_W-1:0] stat_w [NLVL];
  logic [PC_W-1:0] sp_w   [NLVL];

  // level 0 has no link or saved-status bank
  assign link_w[0] = '0;
  assign stat_w[0] = '0;

  for (genvar g = 1; g < NLVL; g++) begin : g_lvl
    localparam logic [1:0] LV      = 2'(g);
    localparam bit         PRESENT = (g == 2) ? HAS_L2 : ((g == 3) ? HAS_L3 : 1'b1);
    if (PRESENT) begin : g_on
      logic [PC_W-1:0] link_q;
      logic [ST_W-1:0] stat_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          link_q <= '0;
          stat_q <= '0;
        end else if (ent_en && ent_lvl == LV) begin
          link_q <= ent_pc;
          stat_q <= ent_st;
        end else if (wr_en && wr_lvl == LV) begin
          if (wr_sel == BK_LINK) link_q <= wr_data;
          if (wr_sel == BK_STAT) stat_q <= wr_data[ST_W-1:0];
        end
      end
      assign link_w[g] = link_q;
      assign stat_w[g] = stat_q;
    end else begin : g_off
      assign link_w[g] = '0;
      assign stat_w[g] = '0;
    end
  end

  for (genvar s = 0; s < NLVL; s++) begin : g_sp
    localparam logic [1:0] SV = 2'(s);
    logic [PC_W-1:0] sp_r;
    always_ff @(posedge clk) begin
      if (!rst_n)                                         sp_r <= '0;
      else if (wr_en && wr_sel == BK_SP && wr_sp_idx == SV) sp_r <= wr_data;
    end
    assign sp_w[s] = sp_r;
  end

  assign rd_link = link_w[rd_lvl];
  assign rd_stat = stat_w[rd_lvl];
  assign sp_q    = sp_w[sp_idx];

endmodule

// File: rtl/exc_level_ctrl.sv
module exc_level_ctrl
  import exc_lvl_pkg::*;
#(
  parameter int              PC_W        = 64,
  parameter int              ST_W        = 32,
  parameter int              CFG_W       = 32,
  parameter bit              HAS_L2      = 1'b1,
  parameter bit              HAS_L3      = 1'b1,
  parameter logic [PC_W-1:0] VEC_BASE_L1 = 'h1000,
  parameter logic [PC_W-1:0] VEC_BASE_L2 = 'h2000,
  parameter logic [PC_W-1:0] VEC_BASE_L3 = 'h3000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_kind,
  input  logic [PC_W-1:0] req_pc,
  input  logic [ST_W-1:0] req_status,
  input  logic            eret_i,
  input  logic            cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic            bank_we,
  input  logic [1:0]      bank_sel,
  input  logic [PC_W-1:0] bank_wdata,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc,
  output logic            illegal,
  output logic [1:0]      cur_level,
  output logic            cur_secure,
  output logic [ST_W-1:0] cur_status,
  output logic [1:0]      sp_bank,
  output logic [PC_W-1:0] sp_value,
  output logic [PC_W-1:0] cur_link,
  output logic [ST_W-1:0] cur_saved,
  output logic            lvl1_64bit
);

  localparam logic [1:0] RST_LVL = HAS_L3 ? 2'd3 : (HAS_L2 ? 2'd2 : 2'd1);

  pstate_t         ps_q;
  logic            cfg_ns_q, cfg_irq3_q, cfg_fiq3_q, cfg_w64_q;
  logic            redir_valid_q, illegal_q;
  logic [PC_W-1:0] redir_pc_q;

  logic            masked, take;
  logic [1:0]      ent_tgt;
  logic            ent_absent;
  logic [PC_W-1:0] ent_vec;
  logic [ST_W-1:0] ent_saved, live_status;
  logic [1:0]      ret_tgt;
  logic            ret_bad;
  logic [1:0]      sp_idx;
  logic            bank_wr_ok;

  // --- request acceptance -------------------------------------------------
  always_comb begin
    masked = 1'b0;
    if (exc_kind_e'(req_kind) == EK_IRQ) masked = ps_q.daif[1];
    if (exc_kind_e'(req_kind) == EK_FIQ) masked = ps_q.daif[0];
  end

  assign req_ready = !eret_i && !masked;
  assign take      = req_valid && req_ready;

  exc_lvl_route #(.HAS_L2(HAS_L2), .HAS_L3(HAS_L3)) u_route (
    .kind       (req_kind),
    .cur_lvl    (ps_q.lvl),
    .irq_to_top (cfg_irq3_q),
    .fiq_to_top (cfg_fiq3_q),
    .tgt_lvl    (ent_tgt),
    .tgt_absent (ent_absent)
  );

  exc_lvl_vector #(
    .PC_W(PC_W), .BASE_L1(VEC_BASE_L1), .BASE_L2(VEC_BASE_L2), .BASE_L3(VEC_BASE_L3)
  ) u_vec (
    .kind    (req_kind),
    .cur_lvl (ps_q.lvl),
    .tgt_lvl (ent_tgt),
    .vec     (ent_vec)
  );

  // --- status word views --------------------------------------------------
  always_comb begin
    live_status                        = '0;
    live_status[ST_SPSEL]              = ps_q.spsel;
    live_status[ST_LVL_LO +: 2]        = ps_q.lvl;
    live_status[ST_MASK_LO +: 4]       = ps_q.daif;
    ent_saved                          = req_status;
    ent_saved[ST_SPSEL]                = ps_q.spsel;
    ent_saved[ST_LVL_LO +: 2]          = ps_q.lvl;
    ent_saved[ST_MASK_LO +: 4]         = ps_q.daif;
  end

  // --- return legality ----------------------------------------------------
  assign ret_tgt = cur_saved[ST_LVL_LO +: 2];

  always_comb begin
    ret_bad = 1'b0;
    if (ps_q.lvl == 2'd0)                          ret_bad = 1'b1;
    if (ret_tgt > ps_q.lvl)                        ret_bad = 1'b1;
    if (ret_tgt == 2'd2 && (!HAS_L2 || !cfg_ns_q)) ret_bad = 1'b1;
    if (ret_tgt == 2'd3 && !HAS_L3)                ret_bad = 1'b1;
  end

  // --- banked registers ---------------------------------------------------
  assign sp_idx     = (ps_q.spsel && ps_q.lvl != 2'd0) ? ps_q.lvl : 2'd0;
  assign bank_wr_ok = bank_we && !take && !eret_i;

  exc_lvl_bank #(.PC_W(PC_W), .ST_W(ST_W), .HAS_L2(HAS_L2), .HAS_L3(HAS_L3)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_en    (take && !ent_absent),
    .ent_lvl   (ent_tgt),
    .ent_pc    (req_pc),
    .ent_st    (ent_saved),
    .wr_en     (bank_wr_ok),
    .wr_sel    (bank_sel),
    .wr_lvl    (ps_q.lvl),
    .wr_sp_idx (sp_idx),
    .wr_data   (bank_wdata),
    .rd_lvl    (ps_q.lvl),
    .sp_idx    (sp_idx),
    .rd_link   (cur_link),
    .rd_stat   (cur_saved),
    .sp_q      (sp_value)
  );

  // --- state update -------------------------------------------------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q          <= '{lvl: RST_LVL, spsel: 1'b1, daif: 4'hF};
      cfg_ns_q      <= !HAS_L3;
      cfg_irq3_q    <= 1'b0;
      cfg_fiq3_q    <= 1'b0;
      cfg_w64_q     <= 1'b0;
      redir_valid_q <= 1'b0;
      redir_pc_q    <= '0;
      illegal_q     <= 1'b0;
    end else begin
      redir_valid_q <= 1'b0;
      illegal_q     <= 1'b0;
      if (cfg_we) begin
        cfg_ns_q   <= cfg_wdata[CFG_NS];
        cfg_irq3_q <= cfg_wdata[CFG_IRQ3];
        cfg_fiq3_q <= cfg_wdata[CFG_FIQ3];
        cfg_w64_q  <= cfg_wdata[CFG_L1W64];
      end
      if (eret_i) begin
        if (ret_bad) begin
          illegal_q <= 1'b1;
        end else begin
          ps_q.lvl      <= ret_tgt;
          ps_q.spsel    <= cur_saved[ST_SPSEL];
          ps_q.daif     <= cur_saved[ST_MASK_LO +: 4];
          redir_valid_q <= 1'b1;
          redir_pc_q    <= cur_link;
        end
      end else if (take) begin
        if (ent_absent) begin
          illegal_q <= 1'b1;
        end else begin
          ps_q.lvl      <= ent_tgt;
          ps_q.spsel    <= 1'b1;
          ps_q.daif     <= 4'hF;
          redir_valid_q <= 1'b1;
          redir_pc_q    <= ent_vec;
        end
      end
    end
  end

  // --- outputs ------------------------------------------------------------
  assign redir_valid = redir_valid_q;
  assign redir_pc    = redir_pc_q;
  assign illegal     = illegal_q;
  assign cur_level   = ps_q.lvl;
  assign cur_status  = live_status;
  assign sp_bank     = sp_idx;
  assign lvl1_64bit  = cfg_w64_q;
  assign cur_secure  = (ps_q.lvl == 2'd3) ? 1'b1 :
                       (ps_q.lvl == 2'd2) ? 1'b0 : !cfg_ns_q;

endmodule

// File: rtl/exc_level_ctrl_chk.sv
module exc_level_ctrl_chk #(
  parameter int ST_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_kind,
  input logic            eret_i,
  input logic            redir_valid,
  input logic            illegal,
  input logic [1:0]      cur_level,
  input logic            cur_secure,
  input logic [ST_W-1:0] cur_status
);

  AST_NO_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (illegal || cur_level >= $past(cur_level))); // R2

  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (illegal || cur_status[9:6] == 4'hF)); // R5

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd2 && cur_status[7]) |-> !req_ready); // R7

  AST_FIQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd3 && cur_status[6]) |-> !req_ready); // R7

  AST_RET_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    eret_i |-> !req_ready); // R7

  AST_TOP_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level == 2'd3) |-> cur_secure); // R10

  AST_L2_NONSECURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level == 2'd2) |-> !cur_secure); // R10

  AST_ILLEGAL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (cur_level == $past(cur_level) && cur_status == $past(cur_status))); // R11

  AST_REDIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_valid && illegal)); // R6

endmodule

bind exc_level_ctrl exc_level_ctrl_chk #(.ST_W(ST_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_kind    (req_kind),
  .eret_i      (eret_i),
  .redir_valid (redir_valid),
  .illegal     (illegal),
  .cur_level   (cur_level),
  .cur_secure  (cur_secure),
  .cur_status  (cur_status)
);

// File: tb/tb_exc_level_ctrl.sv
`timescale 1ns/1ps
module tb_exc_level_ctrl;

  localparam int K_SVC = 0, K_SMC = 1, K_IRQ = 2, K_FIQ = 3, K_ABT = 4;
  localparam int B_LINK = 0, B_STAT = 1, B_SP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [63:0] req_pc = '0;
  logic [31:0] req_status = '0;
  logic        eret_i = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        bank_we = 1'b0;
  logic [1:0]  bank_sel = '0;
  logic [63:0] bank_wdata = '0;
  logic        redir_valid, illegal, cur_secure, lvl1_64bit;
  logic [63:0] redir_pc, sp_value, cur_link;
  logic [1:0]  cur_level, sp_bank;
  logic [31:0] cur_status, cur_saved;

  exc_level_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_pc(req_pc), .req_status(req_status), .eret_i(eret_i),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .bank_we(bank_we), .bank_sel(bank_sel),
    .bank_wdata(bank_wdata), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .illegal(illegal), .cur_level(cur_level), .cur_secure(cur_secure),
    .cur_status(cur_status), .sp_bank(sp_bank), .sp_value(sp_value),
    .cur_link(cur_link), .cur_saved(cur_saved), .lvl1_64bit(lvl1_64bit)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic [1:0]  m_lvl = 2'd3;
  logic        m_sps = 1'b1;
  logic [3:0]  m_daif = 4'hF;
  logic [31:0] m_cfg = '0;
  logic [63:0] m_link [4];
  logic [31:0] m_sst [4];
  logic [63:0] m_sp [4];
  logic        m_rv = 1'b0, m_ill = 1'b0;
  logic [63:0] m_rpc = '0;

  function automatic logic [31:0] pack_st(logic [1:0] l, logic s, logic [3:0] d);
    logic [31:0] r = '0;
    r[0] = s; r[3:2] = l; r[9:6] = d;
    return r;
  endfunction

  function automatic logic [1:0] exp_target(int k, logic [1:0] l, logic [31:0] c);
    logic [1:0] fl = (l == 0) ? 2'd1 : l;
    if (k == K_SMC) return 2'd3;
    if (k == K_IRQ) return c[1] ? 2'd3 : fl;
    if (k == K_FIQ) return c[2] ? 2'd3 : fl;
    return fl;
  endfunction

  function automatic logic [63:0] exp_vec(int k, logic [1:0] t, logic [1:0] l);
    logic [63:0] v = (t == 1) ? 64'h1000 : (t == 2) ? 64'h2000 : 64'h3000;
    if (k == K_IRQ) v += 64'h080;
    if (k == K_FIQ) v += 64'h100;
    v += (t == l) ? 64'h200 : 64'h400;
    return v;
  endfunction

  function automatic logic [1:0] exp_spi();
    return (m_sps && m_lvl != 0) ? m_lvl : 2'd0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_state(string ctx);
    chk({ctx, " level"},   64'(cur_level), 64'(m_lvl));
    chk({ctx, " R10 secure"}, 64'(cur_secure),
        64'((m_lvl == 3) ? 1'b1 : (m_lvl == 2) ? 1'b0 : !m_cfg[0]));
    chk({ctx, " R10 64bit"}, 64'(lvl1_64bit), 64'(m_cfg[10]));
    chk({ctx, " status"},  64'(cur_status), 64'(pack_st(m_lvl, m_sps, m_daif)));
    chk({ctx, " R9 sp bank"},  64'(sp_bank), 64'(exp_spi()));
    chk({ctx, " R9 sp value"}, sp_value, m_sp[exp_spi()]);
    chk({ctx, " R13 link"},  cur_link, (m_lvl == 0) ? 64'h0 : m_link[m_lvl]);
    chk({ctx, " R13 saved"}, 64'(cur_saved), (m_lvl == 0) ? 64'h0 : 64'(m_sst[m_lvl]));
    chk({ctx, " R6 redir valid"}, 64'(redir_valid), 64'(m_rv));
    if (m_rv) chk({ctx, " R6 redir pc"}, redir_pc, m_rpc);
    chk({ctx, " R11 illegal"}, 64'(illegal), 64'(m_ill));
  endtask

  task automatic op_req(int k, logic [63:0] pc, logic [31:0] st, string ctx);
    logic masked;
    logic [1:0] t;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'(k); req_pc = pc; req_status = st;
    #1;
    masked = (k == K_IRQ && m_daif[1]) || (k == K_FIQ && m_daif[0]);
    chk({ctx, " R7 ready"}, 64'(req_ready), 64'(!masked));
    @(posedge clk);
    m_rv = 1'b0; m_ill = 1'b0;
    if (!masked) begin
      t = exp_target(k, m_lvl, m_cfg);
      m_link[t] = pc;
      m_sst[t]  = (st & ~32'h3CD) | pack_st(m_lvl, m_sps, m_daif);
      m_rpc     = exp_vec(k, t, m_lvl);
      m_lvl = t; m_sps = 1'b1; m_daif = 4'hF; m_rv = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1 check_state(ctx);
  endtask

  task automatic op_ret(string ctx);
    logic [1:0]  n, t;
    logic [31:0] s;
    @(negedge clk);
    eret_i = 1'b1;
    @(posedge clk);
    m_rv = 1'b0; m_ill = 1'b0;
    n = m_lvl; s = (n == 0) ? 32'h0 : m_sst[n]; t = s[3:2];
    if (n == 0 || t > n || (t == 2 && !m_cfg[0])) m_ill = 1'b1;
    else begin
      m_rpc = m_link[n]; m_lvl = t; m_sps = s[0]; m_daif = s[9:6]; m_rv = 1'b1;
    end
    @(negedge clk);
    eret_i = 1'b0;
    #1 check_state(ctx);
  endtask

  task automatic op_bw(int sel, logic [63:0] d, string ctx);
    @(negedge clk);
    bank_we = 1'b1; bank_sel = 2'(sel); bank_wdata = d;
    @(posedge clk);
    m_rv = 1'b0; m_ill = 1'b0;
    if (sel == B_LINK && m_lvl != 0) m_link[m_lvl] = d;
    if (sel == B_STAT && m_lvl != 0) m_sst[m_lvl] = d[31:0];
    if (sel == B_SP) m_sp[exp_spi()] = d;
    @(negedge clk);
    bank_we = 1'b0;
    #1 check_state(ctx);
  endtask

  task automatic op_cfg(logic [31:0] d, string ctx);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk);
    m_rv = 1'b0; m_ill = 1'b0; m_cfg = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1 check_state(ctx);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < 4; i++) begin
      m_link[i] = '0; m_sst[i] = '0; m_sp[i] = '0;
    end
    seed = $urandom(32'h5EED_2024);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 check_state("R1 reset");

    // boot hand-off
    op_bw(B_STAT, 64'h3C5, "R13 status write at 3");
    op_bw(B_LINK, 64'h8000, "R13 link write at 3");
    op_bw(B_SP, 64'h33, "R9 sp3 write");
    op_ret("R12 boot to level 1");
    chk("R12 landed level", 64'(cur_level), 64'd1);
    op_cfg(32'h401, "R10 non-secure 64-bit");
    op_bw(B_SP, 64'h11, "R9 sp1 write");
    op_bw(B_STAT, 64'h0, "R13 status write at 1");
    op_bw(B_LINK, 64'h4000, "R13 link write at 1");
    op_ret("R8 drop to level 0");
    op_bw(B_SP, 64'hA0, "R9 sp0 write");
    op_bw(B_LINK, 64'h1234, "R13 link ignored at 0");
    op_req(K_SVC, 64'h4040, 32'hF000_0000, "R2 R5 R6 svc from 0");
    op_bw(B_SP, 64'hB1, "R9 sp1 rewrite");
    op_req(K_ABT, 64'h5550, 32'h0, "R2 R5 R6 abort same level");
    op_ret("R8 return from abort");
    op_bw(B_STAT, 64'h0, "R13 status write");
    op_bw(B_LINK, 64'h4100, "R13 link write");
    op_ret("R9 sp0 kept after return");
    op_req(K_IRQ, 64'h4200, 32'h0, "R4 irq to level 1");
    op_req(K_IRQ, 64'h0, 32'h0, "R7 irq masked");
    op_req(K_FIQ, 64'h0, 32'h0, "R7 fiq masked");
    op_req(K_SMC, 64'h6000, 32'h0, "R3 smc to top");
    op_ret("R8 return from monitor");
    op_bw(B_STAT, 64'h3C8, "R13 status upward");
    op_ret("R11 return above current");
    op_bw(B_STAT, 64'h0, "R13 status write");
    op_ret("R8 drop to 0 again");
    op_ret("R11 return at level 0");
    op_cfg(32'h006, "R4 route irq fiq to top");
    op_req(K_IRQ, 64'h7000, 32'h0, "R4 irq routed to 3");
    op_bw(B_STAT, 64'h3C9, "R13 status to level 2");
    op_ret("R11 level 2 while secure");
    op_cfg(32'h001, "R10 set non-secure");
    op_ret("R10 enter level 2");
    op_req(K_SVC, 64'h7100, 32'h0, "R2 svc at level 2 stays");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int unsigned r = $urandom % 10;
      if (r < 3)      op_req(int'($urandom % 5), {$urandom, $urandom}, $urandom, "random req");
      else if (r < 5) op_ret("random ret");
      else if (r < 8) op_bw(int'($urandom % 3), {$urandom, $urandom}, "random bank");
      else            op_cfg($urandom & 32'h407, "random cfg");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule